// File: doc/BRIEF.md
# Smart Card Coupler Host Control Port

This block is the host-facing control port of a smart card coupler. The host reaches it over a narrow parallel bus made up of an active-low select, a program strobe, two address lines and two data lines. The data lines are shared with the card reset and card data signals. While the select is low the port samples the bus. When the select returns high, the last sampled command is decoded into the coupler configuration: card supply level, card clock divide ratio, card clock run/stop mode and card-detect switch polarity.

A single status output reports card presence, battery health or converter health. The address and program lines choose which one. Battery health is reported in inverted form, so that a coupler that starts on a weak battery still gives a meaningful level. While the port is deselected it ignores the whole bus. Several ports can therefore share one bus, each with its own select. The port also holds the card power enable. The host can raise it only while the port is selected, and the enable drops when the card is withdrawn.

Top module: `scc_host_port`

## Requirements
- R1: A command takes effect only on a rising edge of `cs_n`. The configuration outputs change one clock after the first clock that sees `cs_n` high, and they use the `pgm`, `addr`, `rst_dat` and `io_dat` values sampled on the last clock that saw `cs_n` low.
- R2: After a synchronous `rst`, the outputs are `vsel_5v`=0 (3.0 V), `clk_div`=0 (1/1), `clk_mode`=0 (running), `det_nc`=0 (normally-open switch) and `pwr_en`=0.
- R3: A command with `pgm`=1 writes one field, chosen by `addr`. Address 0 sets `vsel_5v` from `io_dat`. Address 1 sets `clk_div` to {`rst_dat`,`io_dat`}, with 0=1/1, 1=1/2, 2=1/4 and 3=1/8. Address 2 sets `clk_mode` to {`rst_dat`,`io_dat`}, with 0=run, 1=stopped low, 2=stopped high and 3=run. Address 3 sets `det_nc` from `io_dat`. The other fields keep their values.
- R4: `status` is 1 whenever `cs_n`=1 or `pgm`=1. This is the unused register range.
- R5: With `cs_n`=0 and `pgm`=0, `status` follows the address. Address 0 or 3 gives `card_present`. Address 1 gives the inverse of `bat_ok`, so a healthy battery reads 0. Address 2 gives `dcdc_ok`.
- R6: A command with `pgm`=0, and any bus activity while `cs_n`=1, leaves every configuration output unchanged.
- R7: `pwr_en` becomes 1 only at a clock where `cs_n`=0, `pwr_on`=1 and the card is present. While `cs_n`=0 and the card is present, `pwr_en` follows `pwr_on` with a one-clock delay. While `cs_n`=1, `pwr_en` holds its value.
- R8: While `bat_ok`=0, the configuration is forced to the R2 values one clock later, and `pwr_en` is forced to 0.
- R9: `card_present` is combinational. It equals `~card_sw` when `det_nc`=0 and `card_sw` when `det_nc`=1.
- R10: If the card is absent at a clock edge, `pwr_en` is 0 after that edge, whatever the state of `cs_n` and `pwr_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low port select |
| pgm | input | 1 | Program strobe: 1 = write command, 0 = status access |
| addr | input | 2 | Field / status select |
| rst_dat | input | 1 | Card reset line used as the upper data bit |
| io_dat | input | 1 | Card data line used as the lower data bit |
| pwr_on | input | 1 | Host request for card power |
| card_sw | input | 1 | Raw card-detect switch level |
| bat_ok | input | 1 | Battery above threshold |
| dcdc_ok | input | 1 | Card supply converter in regulation |
| vsel_5v | output | 1 | Card supply select: 0 = 3.0 V, 1 = 5.0 V |
| clk_div | output | 2 | Card clock divide code |
| clk_mode | output | 2 | Card clock run/stop code |
| det_nc | output | 1 | Detect polarity: 0 = normally open, 1 = normally closed |
| card_present | output | 1 | Decoded card presence |
| pwr_en | output | 1 | Card power enable |
| status | output | 1 | Multiplexed status bit |

## Verification
The assertions assume that the bus inputs are synchronous to `clk` and stable for at least one clock while `cs_n` is low, so that the last sampled command is well defined. They also assume that `bat_ok` is a clean level. The stimulus changes inputs only just after a rising clock edge. Every select pulse is held low for two or more clocks. Battery drops, card removal and bus activity while deselected are each applied on their own, between complete commands, so that each effect is seen in isolation before a randomized phase mixes them.

// File: rtl/scc_pkg.sv
package scc_pkg;
    localparam int ADDR_W = 2;
    localparam int FLD_W  = 2;

    typedef enum logic [FLD_W-1:0] {
        DIV_1 = 2'd0, DIV_2 = 2'd1, DIV_4 = 2'd2, DIV_8 = 2'd3
    } div_e;

    typedef enum logic [FLD_W-1:0] {
        CK_RUN = 2'd0, CK_STOP_LO = 2'd1, CK_STOP_HI = 2'd2, CK_RUN_ALT = 2'd3
    } ckmode_e;

    typedef enum logic [ADDR_W-1:0] {
        FA_SUPPLY = 2'd0, FA_DIV = 2'd1, FA_MODE = 2'd2, FA_DETPOL = 2'd3
    } field_e;

    typedef struct packed {
        logic    vsel;
        div_e    div;
        ckmode_e ckmode;
        logic    det_nc;
    } cfg_t;

    typedef struct packed {
        logic              pgm;
        logic [ADDR_W-1:0] addr;
        logic              d_hi;
        logic              d_lo;
    } cmd_t;

    localparam cfg_t CFG_RESET = '{vsel: 1'b0, div: DIV_1, ckmode: CK_RUN, det_nc: 1'b0};

    function automatic cfg_t apply_cmd(cfg_t cur, cmd_t c);
        cfg_t nxt;
        nxt = cur;
        if (c.pgm) begin
            case (field_e'(c.addr))
                FA_SUPPLY: nxt.vsel   = c.d_lo;
                FA_DIV:    nxt.div    = div_e'({c.d_hi, c.d_lo});
                FA_MODE:   nxt.ckmode = ckmode_e'({c.d_hi, c.d_lo});
                default:   nxt.det_nc = c.d_lo;
            endcase
        end
        return nxt;
    endfunction
endpackage

// File: rtl/scc_capture.sv
module scc_capture
    import scc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  cmd_t cmd_in,
    output cmd_t cmd_q,
    output logic wr_stb
);
    logic cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q  <= 1'b1;
            cmd_q <= '0;
        end else begin
            cs_q <= cs_n;
            if (!cs_n) cmd_q <= cmd_in;
        end
    end

    assign wr_stb = !cs_q && cs_n;

    // R1: a strobe is only ever raised while the select is high
    a_r1_strobe_on_release: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> $past(!cs_n));
endmodule

// File: rtl/scc_cfg_regs.sv
module scc_cfg_regs
    import scc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bat_ok,
    input  logic wr_stb,
    input  cmd_t cmd,
    output cfg_t cfg
);
    always_ff @(posedge clk) begin
        if (rst || !bat_ok)
            cfg <= CFG_RESET;
        else if (wr_stb)
            cfg <= apply_cmd(cfg, cmd);
    end
endmodule

// File: rtl/scc_power.sv
module scc_power (
    input  logic clk,
    input  logic rst,
    input  logic bat_ok,
    input  logic cs_n,
    input  logic pwr_on,
    input  logic present,
    output logic pwr_en
);
    always_ff @(posedge clk) begin
        if (rst || !bat_ok || !present)
            pwr_en <= 1'b0;
        else if (!cs_n)
            pwr_en <= pwr_on;
    end

    // R7: power only comes up through a selected request
    a_r7_pwr_needs_select: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_en) |-> ($past(!cs_n) && $past(pwr_on)));
    // R10: absence of the card removes power
    a_r10_absent_drops_power: assert property (@(posedge clk) disable iff (rst)
        !present |=> !pwr_en);
endmodule

// File: rtl/scc_status.sv
module scc_status
    import scc_pkg::*;
(
    input  logic              cs_n,
    input  logic              pgm,
    input  logic [ADDR_W-1:0] addr,
    input  logic              present,
    input  logic              bat_ok,
    input  logic              dcdc_ok,
    output logic              status
);
    always_comb begin
        if (cs_n || pgm) begin
            status = 1'b1;
        end else begin
            case (field_e'(addr))
                FA_DIV:  status = !bat_ok;
                FA_MODE: status = dcdc_ok;
                default: status = present;
            endcase
        end
    end
endmodule

// File: rtl/scc_host_port.sv
module scc_host_port
    import scc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              pgm,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rst_dat,
    input  logic              io_dat,
    input  logic              pwr_on,
    input  logic              card_sw,
    input  logic              bat_ok,
    input  logic              dcdc_ok,
    output logic              vsel_5v,
    output logic [FLD_W-1:0]  clk_div,
    output logic [FLD_W-1:0]  clk_mode,
    output logic              det_nc,
    output logic              card_present,
    output logic              pwr_en,
    output logic              status
);
    cmd_t cmd_in, cmd_q;
    cfg_t cfg;
    logic wr_stb;

    assign cmd_in = '{pgm: pgm, addr: addr, d_hi: rst_dat, d_lo: io_dat};

    scc_capture u_capture (
        .clk(clk), .rst(rst), .cs_n(cs_n), .cmd_in(cmd_in),
        .cmd_q(cmd_q), .wr_stb(wr_stb)
    );

    scc_cfg_regs u_cfg (
        .clk(clk), .rst(rst), .bat_ok(bat_ok), .wr_stb(wr_stb),
        .cmd(cmd_q), .cfg(cfg)
    );

    assign vsel_5v      = cfg.vsel;
    assign clk_div      = cfg.div;
    assign clk_mode     = cfg.ckmode;
    assign det_nc       = cfg.det_nc;
    assign card_present = cfg.det_nc ? card_sw : !card_sw;

    scc_power u_power (
        .clk(clk), .rst(rst), .bat_ok(bat_ok), .cs_n(cs_n),
        .pwr_on(pwr_on), .present(card_present), .pwr_en(pwr_en)
    );

    scc_status u_status (
        .cs_n(cs_n), .pgm(pgm), .addr(addr), .present(card_present),
        .bat_ok(bat_ok), .dcdc_ok(dcdc_ok), .status(status)
    );

    // R2: defaults after reset
    a_r2_reset_defaults: assert property (@(posedge clk)
        rst |=> (!vsel_5v && clk_div == 2'd0 && clk_mode == 2'd0 && !det_nc && !pwr_en));
    // R4: idle / unused range reads high
    a_r4_status_idle_high: assert property (@(posedge clk) disable iff (rst)
        (cs_n || pgm) |-> status);
    // R5: battery reported inverted
    a_r5_bat_inverted: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !pgm && addr == 2'd1) |-> (status != bat_ok));
    // R6: configuration stable across a deselected interval
    a_r6_hold_deselected: assert property (@(posedge clk) disable iff (rst)
        ($past(cs_n) && $past(cs_n, 2) && !$past(rst) && $past(bat_ok))
        |-> ($stable(vsel_5v) && $stable(clk_div) && $stable(clk_mode) && $stable(det_nc)));
    // R8: weak battery restores defaults
    a_r8_lowbat_defaults: assert property (@(posedge clk) disable iff (rst)
        !bat_ok |=> (!vsel_5v && clk_div == 2'd0 && clk_mode == 2'd0 && !det_nc && !pwr_en));
endmodule

// File: tb/scc_host_port_bench.sv
module scc_host_port_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, pgm = 1'b0, rst_dat = 1'b0, io_dat = 1'b0;
    logic [1:0] addr = 2'd0;
    logic pwr_on = 1'b0, card_sw = 1'b0, bat_ok = 1'b1, dcdc_ok = 1'b1;
    logic vsel_5v, det_nc, card_present, pwr_en, status;
    logic [1:0] clk_div, clk_mode;

    always #2 clk = ~clk;

    scc_host_port u_scc_host_port (
        .clk(clk), .rst(rst), .cs_n(cs_n), .pgm(pgm), .addr(addr),
        .rst_dat(rst_dat), .io_dat(io_dat), .pwr_on(pwr_on), .card_sw(card_sw),
        .bat_ok(bat_ok), .dcdc_ok(dcdc_ok), .vsel_5v(vsel_5v), .clk_div(clk_div),
        .clk_mode(clk_mode), .det_nc(det_nc), .card_present(card_present),
        .pwr_en(pwr_en), .status(status)
    );

    int n_cmp = 0, n_bad = 0, cycles = 0;
    bit started = 0;
    bit done = 0;
    string req = "R2";

    // reference state
    int m_vsel = 0, m_div = 0, m_mode = 0, m_det = 0, m_pwr = 0;
    int m_prev_cs = 1, m_sh_pgm = 0, m_sh_addr = 0, m_sh_hi = 0, m_sh_lo = 0;

    function automatic int pres_of(int det, logic sw);
        return det != 0 ? int'(sw) : int'(!sw);
    endfunction

    always @(posedge clk) begin
        int pres;
        pres = pres_of(m_det, card_sw);
        if (rst || !bat_ok || pres == 0) m_pwr = 0;
        else if (!cs_n) m_pwr = int'(pwr_on);
        if (rst || !bat_ok) begin
            m_vsel = 0; m_div = 0; m_mode = 0; m_det = 0;
        end else if (m_prev_cs == 0 && cs_n && m_sh_pgm != 0) begin
            case (m_sh_addr)
                0: m_vsel = m_sh_lo;
                1: m_div  = m_sh_hi * 2 + m_sh_lo;
                2: m_mode = m_sh_hi * 2 + m_sh_lo;
                default: m_det = m_sh_lo;
            endcase
        end
        if (rst) begin
            m_prev_cs = 1; m_sh_pgm = 0; m_sh_addr = 0; m_sh_hi = 0; m_sh_lo = 0;
        end else begin
            if (!cs_n) begin
                m_sh_pgm = int'(pgm); m_sh_addr = int'(addr);
                m_sh_hi = int'(rst_dat); m_sh_lo = int'(io_dat);
            end
            m_prev_cs = int'(cs_n);
        end
        started = 1;
    end

    task automatic cmp(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            int pres, st;
            pres = pres_of(m_det, card_sw);
            if (cs_n || pgm) st = 1;
            else case (addr)
                2'd1: st = int'(!bat_ok);
                2'd2: st = int'(dcdc_ok);
                default: st = pres;
            endcase
            cmp("vsel_5v", int'(vsel_5v), m_vsel);
            cmp("clk_div", int'(clk_div), m_div);
            cmp("clk_mode", int'(clk_mode), m_mode);
            cmp("det_nc", int'(det_nc), m_det);
            cmp("card_present", int'(card_present), pres);
            cmp("pwr_en", int'(pwr_en), m_pwr);
            cmp("status", int'(status), st);
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic cmd(logic p, logic [1:0] a, logic hi, logic lo);
        cs_n = 1'b0; pgm = p; addr = a; rst_dat = hi; io_dat = lo;
        tick(2);
        cs_n = 1'b1;
        pgm = ~p; addr = ~a; rst_dat = ~hi; io_dat = ~lo;  // R6: noise after release
        tick(2);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 50000", cycles);
            finish_run();
        end
    end

    initial begin
        tick(3);
        req = "R2"; rst = 1'b0; tick(2);
        req = "R3"; cmd(1, 2'd0, 0, 1);
        for (int d = 0; d < 4; d++) cmd(1, 2'd1, d[1], d[0]);
        for (int d = 0; d < 4; d++) cmd(1, 2'd2, d[1], d[0]);
        req = "R1"; cs_n = 0; pgm = 1; addr = 2'd1; rst_dat = 1; io_dat = 0; tick(1);
        rst_dat = 0; io_dat = 1; tick(1); cs_n = 1; tick(2);
        req = "R6"; cmd(0, 2'd1, 1, 1); cmd(0, 2'd0, 0, 0);
        for (int i = 0; i < 8; i++) begin pgm = i[0]; addr = i[1:0]; io_dat = i[2]; tick(1); end
        req = "R5";
        for (int a = 0; a < 4; a++) begin
            cs_n = 0; pgm = 0; addr = a[1:0]; tick(1);
            bat_ok = 1; dcdc_ok = 0; tick(1); dcdc_ok = 1; tick(1);
        end
        req = "R4"; pgm = 1; tick(2); cs_n = 1; pgm = 0; tick(2);
        req = "R9"; cmd(1, 2'd3, 0, 1); card_sw = 1; tick(2); card_sw = 0; tick(2);
        cmd(1, 2'd3, 0, 0);
        req = "R7"; pwr_on = 1; tick(3); cs_n = 0; tick(3); cs_n = 1; pwr_on = 0; tick(3);
        cs_n = 0; tick(2); pwr_on = 1; tick(2); cs_n = 1; tick(2);
        req = "R10"; card_sw = 1; tick(3); card_sw = 0; cs_n = 0; tick(3); cs_n = 1; tick(1);
        req = "R8"; cmd(1, 2'd0, 0, 1); cmd(1, 2'd2, 1, 0); bat_ok = 0; tick(1);
        cmd(1, 2'd1, 1, 1); bat_ok = 1; tick(2);
        req = "R3";
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom;
            cs_n = r[0] | r[1]; pgm = r[2]; addr = r[4:3]; rst_dat = r[5]; io_dat = r[6];
            pwr_on = r[7]; card_sw = (r[12:8] == 0); dcdc_ok = r[13];
            bat_ok = (r[20:14] != 0);
            tick(1);
        end
        bat_ok = 1; cs_n = 1; tick(2);
        finish_run();
    end
endmodule